// File: doc/BRIEF.md
# Serial Multiprocessor Address Filter

This block sits after the bit sampler of an asynchronous serial receiver that can carry a ninth data bit. Each time the sampler finishes a frame it raises a one-cycle strobe and presents the eight data bits, the extra bit (the ninth bit in the 11-bit modes, or the stop bit in the 10-bit mode), the selected mode and the multiprocessor-enable control. The filter decides whether the frame reaches software. An accepted frame is copied into the receive buffer, its extra bit is kept, and the receive flag goes high. A rejected frame leaves every output as it was.

In multiprocessor operation a node only wakes up for address frames that name it. The node keeps an address register and a mask register. A mask bit of 0 makes the matching address bit don't-care. The node also answers a broadcast address, formed as the OR of address and mask, where every 0 bit of that OR is don't-care. Address frames carry a ninth bit of 1. In the 10-bit mode the same enable instead requires a valid stop bit. The two registers are loaded through a small write port.

Top module: `mp_addr_filter`

## Requirements
- R1: After synchronous reset, rx_flag, buf_load, rx_data, rx_bit9 and both configuration registers are 0.
- R2: With mp_en = 0, every completed frame in every mode is accepted. On the clock edge that samples frm_done, buf_load pulses high for one cycle, rx_data takes frm_data, rx_bit9 takes frm_bit9, and rx_flag goes to 1.
- R3: In mode 0 (mode = 2'b00, shift mode) mp_en has no effect, and every frame is accepted whatever frm_bit9 is.
- R4: In mode 1 (mode = 2'b01, 10-bit frame) with mp_en = 1, a frame is accepted only when frm_bit9 (the stop bit) is 1.
- R5: In modes 2 and 3 (mode = 2'b10 or 2'b11, 11-bit frame) with mp_en = 1, a frame whose ninth bit is 0 is rejected whatever its data is.
- R6: In modes 2 and 3 with mp_en = 1 and ninth bit 1, a frame is accepted when frm_data equals the address register on every bit where the mask register is 1.
- R7: In modes 2 and 3 with mp_en = 1 and ninth bit 1, a frame is accepted when frm_data has a 1 in every bit position where (address OR mask) is 1.
- R8: A frame that meets neither R6 nor R7 under R5's conditions is rejected: buf_load stays 0, and rx_flag, rx_data and rx_bit9 keep their values.
- R9: A frame that completes while rx_flag is 1 and flag_clr is 0 is discarded: no buf_load, and rx_data and rx_bit9 are unchanged.
- R10: flag_clr = 1 clears rx_flag on the next edge. When it coincides with frm_done, the buffer is treated as empty, and an accepted frame loads and leaves rx_flag at 1.
- R11: With cfg_we = 1, cfg_sel = 0 writes cfg_wdata to the address register and cfg_sel = 1 writes it to the mask register. The new value governs frames from the next cycle on.
- R12: buf_load is high only in the cycle after an accepted frame, never for two cycles in a row.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 1 | 0 selects address register, 1 selects mask register |
| cfg_wdata | input | 8 | Configuration write data |
| frm_done | input | 1 | One-cycle strobe: a frame has been sampled |
| frm_data | input | 8 | Received data bits |
| frm_bit9 | input | 1 | Ninth bit (modes 2/3) or stop bit (mode 1) |
| mode | input | 2 | Serial mode 0..3 |
| mp_en | input | 1 | Multiprocessor / stop-bit qualification enable |
| flag_clr | input | 1 | Clears the receive flag |
| buf_load | output | 1 | One-cycle pulse when the buffer is loaded |
| rx_data | output | 8 | Receive buffer |
| rx_bit9 | output | 1 | Stored ninth or stop bit |
| rx_flag | output | 1 | Receive flag |

## Verification
The address and mask are set so that the unicast match (upper nibble fixed, lower nibble don't-care) and the broadcast set (four values) do not overlap. Each stimulus vector then shows which of the two paths accepted the frame, and a near-miss value checks that neither path accepts it alone. The same data bytes are also sent with the ninth bit cleared, with mp_en cleared and in each mode. This separates the address filtering from the stop-bit rule and from the pass-through case. Directed cases cover a frame arriving onto a full buffer, a clear arriving in the same cycle as a frame, and a change of mask that makes one address fall out of the match while broadcast still picks up another.

// File: rtl/mpf_pkg.sv
package mpf_pkg;
  typedef enum logic [1:0] {
    MODE_SHIFT   = 2'b00,
    MODE_TEN_BIT = 2'b01,
    MODE_ELEVEN_A = 2'b10,
    MODE_ELEVEN_B = 2'b11
  } rx_mode_e;

  typedef enum logic {
    SEL_ADDR = 1'b0,
    SEL_MASK = 1'b1
  } cfg_sel_e;
endpackage

// File: rtl/mpf_cfg_regs.sv
module mpf_cfg_regs #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic          sel,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] addr_q,
  output logic [DW-1:0] mask_q
);
  import mpf_pkg::*;

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_q <= '0;
      mask_q <= '0;
    end else if (we) begin
      if (cfg_sel_e'(sel) == SEL_ADDR) addr_q <= wdata;
      else                             mask_q <= wdata;
    end
  end
endmodule

// File: rtl/mpf_addr_match.sv
module mpf_addr_match #(
  parameter int DW = 8
) (
  input  logic [DW-1:0] data,
  input  logic [DW-1:0] addr,
  input  logic [DW-1:0] mask,
  output logic          hit_own,
  output logic          hit_bcast
);
  logic [DW-1:0] own_ok;
  logic [DW-1:0] bc_ok;

  // Per-bit compare: a bit passes when it is don't-care or it agrees.
  for (genvar i = 0; i < DW; i++) begin : g_bit
    assign own_ok[i] = ~mask[i] | ~(data[i] ^ addr[i]);
    assign bc_ok[i]  = ~(addr[i] | mask[i]) | data[i];
  end

  assign hit_own   = &own_ok;
  assign hit_bcast = &bc_ok;
endmodule

// File: rtl/mpf_accept.sv
module mpf_accept (
  input  logic       frm_done,
  input  logic [1:0] mode,
  input  logic       mp_en,
  input  logic       bit9,
  input  logic       hit_own,
  input  logic       hit_bcast,
  input  logic       flag_q,
  input  logic       flag_clr,
  output logic       accept
);
  import mpf_pkg::*;

  logic qualified;
  logic buf_full;

  always_comb begin
    qualified = 1'b1;
    if (mp_en) begin
      unique case (rx_mode_e'(mode))
        MODE_SHIFT:    qualified = 1'b1;
        MODE_TEN_BIT:  qualified = bit9;
        MODE_ELEVEN_A,
        MODE_ELEVEN_B: qualified = bit9 & (hit_own | hit_bcast);
        default:       qualified = 1'b1;
      endcase
    end
  end

  // A clear in the same cycle empties the buffer before the new frame.
  assign buf_full = flag_q & ~flag_clr;
  assign accept   = frm_done & qualified & ~buf_full;
endmodule

// File: rtl/mpf_rx_regs.sv
module mpf_rx_regs #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          accept,
  input  logic          flag_clr,
  input  logic [DW-1:0] data,
  input  logic          bit9,
  output logic          load_q,
  output logic [DW-1:0] data_q,
  output logic          bit9_q,
  output logic          flag_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      load_q <= 1'b0;
      data_q <= '0;
      bit9_q <= 1'b0;
      flag_q <= 1'b0;
    end else begin
      load_q <= accept;
      if (accept) begin
        data_q <= data;
        bit9_q <= bit9;
        flag_q <= 1'b1;
      end else if (flag_clr) begin
        flag_q <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/mp_addr_filter.sv
module mp_addr_filter #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic              cfg_sel,
  input  logic [DATA_W-1:0] cfg_wdata,
  input  logic              frm_done,
  input  logic [DATA_W-1:0] frm_data,
  input  logic              frm_bit9,
  input  logic [1:0]        mode,
  input  logic              mp_en,
  input  logic              flag_clr,
  output logic              buf_load,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_bit9,
  output logic              rx_flag
);
  logic [DATA_W-1:0] addr_q;
  logic [DATA_W-1:0] mask_q;
  logic              hit_own;
  logic              hit_bcast;
  logic              accept;

  mpf_cfg_regs #(.DW(DATA_W)) u_cfg (
    .clk    (clk),
    .rst    (rst),
    .we     (cfg_we),
    .sel    (cfg_sel),
    .wdata  (cfg_wdata),
    .addr_q (addr_q),
    .mask_q (mask_q)
  );

  mpf_addr_match #(.DW(DATA_W)) u_match (
    .data      (frm_data),
    .addr      (addr_q),
    .mask      (mask_q),
    .hit_own   (hit_own),
    .hit_bcast (hit_bcast)
  );

  mpf_accept u_acc (
    .frm_done  (frm_done),
    .mode      (mode),
    .mp_en     (mp_en),
    .bit9      (frm_bit9),
    .hit_own   (hit_own),
    .hit_bcast (hit_bcast),
    .flag_q    (rx_flag),
    .flag_clr  (flag_clr),
    .accept    (accept)
  );

  mpf_rx_regs #(.DW(DATA_W)) u_rx (
    .clk      (clk),
    .rst      (rst),
    .accept   (accept),
    .flag_clr (flag_clr),
    .data     (frm_data),
    .bit9     (frm_bit9),
    .load_q   (buf_load),
    .data_q   (rx_data),
    .bit9_q   (rx_bit9),
    .flag_q   (rx_flag)
  );
endmodule

// File: rtl/mpf_checker.sv
module mpf_checker #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              frm_done,
  input logic [DATA_W-1:0] frm_data,
  input logic              frm_bit9,
  input logic [1:0]        mode,
  input logic              mp_en,
  input logic              flag_clr,
  input logic              buf_load,
  input logic [DATA_W-1:0] rx_data,
  input logic              rx_bit9,
  input logic              rx_flag
);
  AST_OPEN_ACCEPT: assert property (@(posedge clk) disable iff (rst)
    (frm_done && !mp_en && !(rx_flag && !flag_clr)) |=> buf_load); // R2

  AST_SHIFT_ACCEPT: assert property (@(posedge clk) disable iff (rst)
    (frm_done && mode == 2'b00 && !(rx_flag && !flag_clr)) |=> buf_load); // R3

  AST_STOP_QUAL: assert property (@(posedge clk) disable iff (rst)
    (frm_done && mp_en && mode == 2'b01 && !frm_bit9) |=> !buf_load); // R4

  AST_NINTH_QUAL: assert property (@(posedge clk) disable iff (rst)
    (frm_done && mp_en && mode[1] && !frm_bit9) |=> !buf_load); // R5

  AST_FULL_DISCARD: assert property (@(posedge clk) disable iff (rst)
    (rx_flag && !flag_clr) |=> !buf_load); // R9

  AST_CLR_ALONE: assert property (@(posedge clk) disable iff (rst)
    (flag_clr && !frm_done) |=> !rx_flag); // R10

  AST_LOAD_CAPTURE: assert property (@(posedge clk) disable iff (rst)
    frm_done |=> (!buf_load || (rx_data == $past(frm_data) && rx_bit9 == $past(frm_bit9)))); // R2

  AST_BUF_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!frm_done) |=> ($stable(rx_data) && $stable(rx_bit9))); // R8

  AST_LOAD_PULSE: assert property (@(posedge clk) disable iff (rst)
    buf_load |=> !buf_load); // R12
endmodule

bind mp_addr_filter mpf_checker #(.DATA_W(DATA_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .frm_done (frm_done),
  .frm_data (frm_data),
  .frm_bit9 (frm_bit9),
  .mode     (mode),
  .mp_en    (mp_en),
  .flag_clr (flag_clr),
  .buf_load (buf_load),
  .rx_data  (rx_data),
  .rx_bit9  (rx_bit9),
  .rx_flag  (rx_flag)
);

// File: tb/mp_addr_filter_test.sv
module mp_addr_filter_test;
  localparam int DW = 8;

  logic          clk = 1'b0;
  logic          rst;
  logic          cfg_we, cfg_sel, frm_done, frm_bit9, mp_en, flag_clr;
  logic [DW-1:0] cfg_wdata, frm_data;
  logic [1:0]    mode;
  logic          buf_load, rx_bit9, rx_flag;
  logic [DW-1:0] rx_data;

  int n_run  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  logic [DW-1:0] exp_data = '0;
  logic          exp_b9   = 1'b0;

  always #10 clk = ~clk;

  mp_addr_filter #(.DATA_W(DW)) uut (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .frm_done(frm_done), .frm_data(frm_data), .frm_bit9(frm_bit9), .mode(mode),
    .mp_en(mp_en), .flag_clr(flag_clr), .buf_load(buf_load), .rx_data(rx_data),
    .rx_bit9(rx_bit9), .rx_flag(rx_flag)
  );

  typedef struct packed {
    logic [1:0] md;
    logic       mp;
    logic       b9;
    logic [7:0] dat;
    logic       acc;
    logic [3:0] req;
  } vec_t;

  // address 0x5A, mask 0xF0: unicast 0x5?, broadcast needs bits of 0xFA set
  localparam int NV = 12;
  localparam vec_t VECS [NV] = '{
    '{2'd2, 1'b1, 1'b1, 8'h53, 1'b1, 4'd6},  // R6 unicast
    '{2'd2, 1'b1, 1'b1, 8'h63, 1'b0, 4'd8},  // R8 miss
    '{2'd3, 1'b1, 1'b1, 8'hFB, 1'b1, 4'd7},  // R7 broadcast
    '{2'd3, 1'b1, 1'b1, 8'hF8, 1'b0, 4'd8},  // R8 near-miss broadcast
    '{2'd2, 1'b1, 1'b0, 8'h55, 1'b0, 4'd5},  // R5 ninth bit 0
    '{2'd3, 1'b0, 1'b0, 8'h11, 1'b1, 4'd2},  // R2 open
    '{2'd1, 1'b1, 1'b0, 8'h22, 1'b0, 4'd4},  // R4 bad stop
    '{2'd1, 1'b1, 1'b1, 8'h22, 1'b1, 4'd4},  // R4 good stop
    '{2'd0, 1'b1, 1'b0, 8'h99, 1'b1, 4'd3},  // R3 shift mode
    '{2'd1, 1'b0, 1'b0, 8'h44, 1'b1, 4'd2},  // R2 open mode 1
    '{2'd3, 1'b1, 1'b1, 8'hFE, 1'b1, 4'd7},  // R7 broadcast
    '{2'd2, 1'b1, 1'b1, 8'h5F, 1'b1, 4'd6}   // R6 unicast
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic idle();
    cfg_we = 0; cfg_sel = 0; cfg_wdata = '0; frm_done = 0; frm_data = '0;
    frm_bit9 = 0; mode = 2'd0; mp_en = 0; flag_clr = 0;
  endtask

  task automatic cfg_write(input logic sel, input logic [DW-1:0] v);
    @(negedge clk);
    cfg_we = 1; cfg_sel = sel; cfg_wdata = v;
    @(negedge clk);
    cfg_we = 0;
  endtask

  task automatic clear_flag();
    @(negedge clk);
    flag_clr = 1;
    @(negedge clk);
    flag_clr = 0;
  endtask

  // presents a frame for one cycle; returns sampled after the capturing edge
  task automatic send(input logic [1:0] md, input logic mp, input logic b9,
                      input logic [DW-1:0] d, input logic clr);
    @(negedge clk);
    frm_done = 1; mode = md; mp_en = mp; frm_bit9 = b9; frm_data = d; flag_clr = clr;
    @(negedge clk);
    frm_done = 0; flag_clr = 0;
  endtask

  initial begin
    #3000000;
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    idle();
    rst = 1;
    repeat (3) @(negedge clk);
    rst = 0;
    // R1 reset state
    check("R1 rx_flag", rx_flag, 0);
    check("R1 buf_load", buf_load, 0);
    check("R1 rx_data", rx_data, 0);
    check("R1 rx_bit9", rx_bit9, 0);
    // R1 zero mask/address: broadcast all don't-care, any address frame passes
    send(2'd2, 1'b1, 1'b1, 8'h3C, 1'b0);
    check("R1 zero config accepts", buf_load, 1);
    exp_data = 8'h3C; exp_b9 = 1'b1;
    clear_flag();

    // R11 program address and mask
    cfg_write(1'b0, 8'h5A);
    cfg_write(1'b1, 8'hF0);

    for (int i = 0; i < NV; i++) begin
      clear_flag();
      send(VECS[i].md, VECS[i].mp, VECS[i].b9, VECS[i].dat, 1'b0);
      if (VECS[i].acc) begin exp_data = VECS[i].dat; exp_b9 = VECS[i].b9; end
      check($sformatf("R%0d vec%0d load", VECS[i].req, i), buf_load, VECS[i].acc);
      check($sformatf("R%0d vec%0d flag", VECS[i].req, i), rx_flag, VECS[i].acc);
      check($sformatf("R%0d vec%0d data", VECS[i].req, i), rx_data, exp_data);
      check($sformatf("R%0d vec%0d bit9", VECS[i].req, i), rx_bit9, exp_b9);
    end

    // R12 pulse drops after one cycle
    @(negedge clk);
    check("R12 load single cycle", buf_load, 0);

    // R9 flag still set from last vector: new frame discarded
    send(2'd3, 1'b0, 1'b0, 8'hA5, 1'b0);
    check("R9 no load when full", buf_load, 0);
    check("R9 buffer kept", rx_data, exp_data);
    check("R9 bit9 kept", rx_bit9, exp_b9);
    check("R9 flag still set", rx_flag, 1);

    // R10 clear in same cycle as frame: accepted
    send(2'd3, 1'b0, 1'b0, 8'hA5, 1'b1);
    exp_data = 8'hA5; exp_b9 = 1'b0;
    check("R10 clear+frame load", buf_load, 1);
    check("R10 clear+frame flag", rx_flag, 1);
    check("R10 clear+frame data", rx_data, exp_data);
    clear_flag();
    check("R10 clear alone", rx_flag, 0);

    // R11 mask to 0xFF: 0x53 no longer matches, broadcast now 0xFF only
    cfg_write(1'b1, 8'hFF);
    send(2'd2, 1'b1, 1'b1, 8'h53, 1'b0);
    check("R11 narrowed mask rejects", buf_load, 0);
    check("R11 reject keeps data", rx_data, exp_data);
    send(2'd2, 1'b1, 1'b1, 8'h5A, 1'b0);
    check("R11 exact address accepted", buf_load, 1);
    clear_flag();
    send(2'd2, 1'b1, 1'b1, 8'hFF, 1'b0);
    check("R7 broadcast 0xFF accepted", buf_load, 1);
    check("R7 broadcast data", rx_data, 8'hFF);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule